// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides when a processor core stops and passes control to an external debugger. Debug events arrive as one request bit per event type. They are breakpoint match, watchpoint match, software breakpoint instruction, external debug request and vector catch. Each event comes with the return address of the affected instruction, the current instruction-set state and a flag that marks the event as halting-class. When an event is accepted, the block records the cause and holds the core halted until a restart request arrives.

While the core is halted, the block raises a debug acknowledge. It holds off instruction prefetch and masks interrupts. In the first halted cycle it issues a single pipeline flush pulse. It also presents a PC value for debugger reads. That value is captured at entry as the return address plus an offset that depends on the instruction-set state. After that, only an explicit PC write changes it. A 32-bit status word reports three fields: halted (bit 0), entry method (bits [5:2]) and the halting-mode enable (bit 14).

Top module: `dbg_halt_ctrl`

## Requirements
- R1: When status bit 14 (halting enable) is 1 and the core is running, any asserted event request sets the halted state on the next clock.
- R2: An event presented with `evt_halt_class` = 1 puts the core into the halted state on the next clock, even when status bit 14 is 0.
- R3: After entry, status bit 0 reads 1 and `dbg_ack` is 1. Out of reset, the status word reads 0 and `dbg_ack` is 0.
- R4: On entry, status bits [5:2] hold the cause code: `evt_req[0]` breakpoint = 1, `evt_req[1]` watchpoint = 2, `evt_req[2]` software breakpoint = 3, `evt_req[3]` external request = 4, `evt_req[4]` vector catch = 5. Code 0 means running. When several requests arrive together, the lowest code is recorded.
- R5: While halted, `prefetch_hold` and `irq_mask` are 1. `pipe_flush` is 1 only in the first halted cycle.
- R6: While halted, further event requests are ignored, and the entry-method field keeps its value.
- R7: On entry, `pc_rd` becomes `ret_addr` + 8 when `isa_compact` = 0, or `ret_addr` + 4 when `isa_compact` = 1, modulo 2^AW. The same rule applies to all five event types.
- R8: While halted, `pc_rd` keeps its value unless `pc_wr_en` loads `pc_wr_data`. PC writes made while running are ignored.
- R9: A restart request while halted clears status bit 0, the method field, `dbg_ack`, `prefetch_hold` and `irq_mask` on the next clock. A restart request while running has no effect.
- R10: A `cfg_wr_en` write updates only status bit 14, at any time. Status bits 0 and [5:2] cannot be written.
- R11: An event without the halting-class flag is ignored while status bit 14 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_req | input | 5 | Event requests, one bit per type |
| evt_halt_class | input | 1 | Marks the current event as halting-class |
| isa_compact | input | 1 | 1 = 16-bit compressed instruction state |
| ret_addr | input | AW | Return address of the affected instruction |
| restart_req | input | 1 | Leave the halted state |
| cfg_wr_en | input | 1 | Status write strobe |
| cfg_wr_data | input | 32 | Status write data; only bit 14 is used |
| pc_wr_en | input | 1 | Explicit PC write strobe |
| pc_wr_data | input | AW | Explicit PC write value |
| status | output | 32 | Status word: halted, entry method, halting enable |
| dbg_ack | output | 1 | Debug acknowledge |
| pipe_flush | output | 1 | One-cycle pipeline flush request |
| prefetch_hold | output | 1 | Instruction prefetch stall |
| irq_mask | output | 1 | Interrupt mask |
| pc_rd | output | AW | PC value presented to debugger reads |

## Verification
Each result comes from a single register stage. Entry, the cause code, the PC snapshot, the flush pulse, restart and configuration writes all appear on the clock edge that follows the cycle in which the stimulus is held. `pipe_flush` drops again one edge after that. The bench changes inputs on the falling edge and holds them across exactly one rising edge. It then reads the outputs on the next falling edge, so every comparison lands in the cycle the result is due. Cases where the result is that nothing happens (an ignored event, restart or PC write) are checked after the same single edge, and again after later idle edges.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    localparam int NUM_EVT   = 5;
    localparam int CODE_W    = 4;
    localparam int STAT_W    = 32;
    localparam int HALT_BIT  = 0;
    localparam int METH_LO   = 2;
    localparam int METH_HI   = METH_LO + CODE_W - 1;
    localparam int EN_BIT    = 14;

    typedef enum logic [CODE_W-1:0] {
        METH_NONE  = 4'd0,
        METH_BKPT  = 4'd1,
        METH_WATCH = 4'd2,
        METH_SWBK  = 4'd3,
        METH_EXT   = 4'd4,
        METH_VEC   = 4'd5
    } meth_e;

    typedef struct packed {
        logic  halted;
        meth_e meth;
        logic  en;
        logic  flush;
    } ctl_t;
endpackage

// File: rtl/dbg_evt_prio.sv
module dbg_evt_prio #(
    parameter int N      = 5,
    parameter int CODE_W = 4
) (
    input  logic [N-1:0]      evt,
    output logic              any,
    output logic [CODE_W-1:0] code
);
    logic [N:0]   seen;
    logic [N-1:0] sel;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign seen[g+1] = seen[g] | evt[g];
        assign sel[g]    = evt[g] & ~seen[g];
    end

    assign any = seen[N];

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) code = code | CODE_W'(i + 1);
        end
    end
endmodule

// File: rtl/dbg_pc_snap.sv
module dbg_pc_snap #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          compact,
    input  logic [AW-1:0] ret_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] OFS_WIDE   = AW'(8);
    localparam logic [AW-1:0] OFS_NARROW = AW'(4);

    logic [AW-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (capture)    pc_d = ret_addr + (compact ? OFS_NARROW : OFS_WIDE);
        else if (wr_en) pc_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !wr_en) |=> $stable(pc_q));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_req,
    input  logic               evt_halt_class,
    input  logic               isa_compact,
    input  logic [AW-1:0]      ret_addr,
    input  logic               restart_req,
    input  logic               cfg_wr_en,
    input  logic [STAT_W-1:0]  cfg_wr_data,
    input  logic               pc_wr_en,
    input  logic [AW-1:0]      pc_wr_data,
    output logic [STAT_W-1:0]  status,
    output logic               dbg_ack,
    output logic               pipe_flush,
    output logic               prefetch_hold,
    output logic               irq_mask,
    output logic [AW-1:0]      pc_rd
);
    ctl_t ctl_d, ctl_q;
    logic              evt_any;
    logic [CODE_W-1:0] evt_code;
    logic              take;
    logic              cfg_unused;

    assign cfg_unused = ^{cfg_wr_data[STAT_W-1:EN_BIT+1], cfg_wr_data[EN_BIT-1:0]};

    dbg_evt_prio #(.N(NUM_EVT), .CODE_W(CODE_W)) u_prio (
        .evt  (evt_req),
        .any  (evt_any),
        .code (evt_code)
    );

    assign take = !ctl_q.halted && evt_any && (ctl_q.en || evt_halt_class);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = 1'b0;
        if (cfg_wr_en) ctl_d.en = cfg_wr_data[EN_BIT];
        if (ctl_q.halted) begin
            if (restart_req) begin
                ctl_d.halted = 1'b0;
                ctl_d.meth   = METH_NONE;
            end
        end else if (take) begin
            ctl_d.halted = 1'b1;
            ctl_d.meth   = meth_e'(evt_code);
            ctl_d.flush  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{halted: 1'b0, meth: METH_NONE, en: 1'b0, flush: 1'b0};
        else        ctl_q <= ctl_d;
    end

    dbg_pc_snap #(.AW(AW)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (take),
        .compact  (isa_compact),
        .ret_addr (ret_addr),
        .wr_en    (pc_wr_en && ctl_q.halted),
        .wr_data  (pc_wr_data),
        .pc       (pc_rd)
    );

    always_comb begin
        status                  = '0;
        status[HALT_BIT]        = ctl_q.halted;
        status[METH_HI:METH_LO] = ctl_q.meth;
        status[EN_BIT]          = ctl_q.en;
    end

    assign dbg_ack       = ctl_q.halted;
    assign prefetch_hold = ctl_q.halted;
    assign irq_mask      = ctl_q.halted;
    assign pipe_flush    = ctl_q.flush;

    assert_enabled_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[HALT_BIT] && |evt_req && status[EN_BIT]) |=> status[HALT_BIT]);

    assert_halting_class_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[HALT_BIT] && |evt_req && evt_halt_class) |=> dbg_ack);

    assert_method_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[HALT_BIT] && !restart_req) |=> $stable(status[METH_HI:METH_LO]));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[HALT_BIT] && restart_req) |=> (!dbg_ack && status[METH_HI:METH_LO] == '0));

    assert_flush_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |=> !pipe_flush);

    assert_ignored_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[HALT_BIT] && !status[EN_BIT] && !evt_halt_class) |=> !pipe_flush);
endmodule

// File: tb/dbg_halt_ctrl_test.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_test;
    localparam int AW = 32;

    typedef struct packed {
        logic        en;
        logic [4:0]  evt;
        logic        hc;
        logic        cmp;
        logic [31:0] ra;
        logic        eh;
        logic [3:0]  ec;
        logic [31:0] epc;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{1'b1, 5'b00001, 1'b0, 1'b0, 32'h0000_1000, 1'b1, 4'd1, 32'h0000_1008},
        '{1'b1, 5'b00010, 1'b0, 1'b1, 32'h0000_2000, 1'b1, 4'd2, 32'h0000_2004},
        '{1'b1, 5'b00100, 1'b0, 1'b0, 32'h0000_3000, 1'b1, 4'd3, 32'h0000_3008},
        '{1'b1, 5'b01000, 1'b0, 1'b1, 32'h0000_4002, 1'b1, 4'd4, 32'h0000_4006},
        '{1'b1, 5'b10000, 1'b0, 1'b0, 32'h0000_5000, 1'b1, 4'd5, 32'h0000_5008},
        '{1'b0, 5'b00001, 1'b0, 1'b0, 32'h0000_5800, 1'b0, 4'd0, 32'h0000_0000},
        '{1'b0, 5'b01000, 1'b1, 1'b0, 32'h0000_6000, 1'b1, 4'd4, 32'h0000_6008},
        '{1'b1, 5'b11010, 1'b0, 1'b1, 32'h0000_7000, 1'b1, 4'd2, 32'h0000_7004},
        '{1'b0, 5'b10100, 1'b1, 1'b1, 32'h0000_8000, 1'b1, 4'd3, 32'h0000_8004}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    evt_req = '0;
    logic          evt_halt_class = 1'b0;
    logic          isa_compact = 1'b0;
    logic [AW-1:0] ret_addr = '0;
    logic          restart_req = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [31:0]   cfg_wr_data = '0;
    logic          pc_wr_en = 1'b0;
    logic [AW-1:0] pc_wr_data = '0;
    logic [31:0]   status;
    logic          dbg_ack, pipe_flush, prefetch_hold, irq_mask;
    logic [AW-1:0] pc_rd;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dbg_halt_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .evt_halt_class(evt_halt_class),
        .isa_compact(isa_compact), .ret_addr(ret_addr), .restart_req(restart_req),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .pc_wr_en(pc_wr_en),
        .pc_wr_data(pc_wr_data), .status(status), .dbg_ack(dbg_ack),
        .pipe_flush(pipe_flush), .prefetch_hold(prefetch_hold), .irq_mask(irq_mask),
        .pc_rd(pc_rd)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_en(input logic en);
        cfg_wr_en = 1'b1;
        cfg_wr_data = 32'(en) << 14;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset status", status, 32'h0);
        chk("R3 reset ack", 32'(dbg_ack), 32'h0);
        chk("R5 reset side outputs", {29'h0, pipe_flush, prefetch_hold, irq_mask}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            set_en(VT[i].en);
            evt_req = VT[i].evt;
            evt_halt_class = VT[i].hc;
            isa_compact = VT[i].cmp;
            ret_addr = VT[i].ra;
            tick();
            evt_req = '0;
            evt_halt_class = 1'b0;
            chk("R1 R2 R11 halted bit", 32'(status[0]), 32'(VT[i].eh));
            chk("R3 dbg_ack", 32'(dbg_ack), 32'(VT[i].eh));
            chk("R4 entry method", 32'(status[5:2]), 32'(VT[i].ec));
            if (VT[i].eh) chk("R7 pc snapshot", pc_rd, VT[i].epc);
            restart_req = 1'b1;
            tick();
            restart_req = 1'b0;
            chk("R9 restart halted bit", 32'(status[0]), 32'h0);
            chk("R9 restart method", 32'(status[5:2]), 32'h0);
        end

        // Wrap of return address, flush pulse, side outputs
        set_en(1'b1);
        evt_req = 5'b00001;
        isa_compact = 1'b0;
        ret_addr = 32'hFFFF_FFFC;
        tick();
        evt_req = '0;
        chk("R7 wrapped pc", pc_rd, 32'h0000_0004);
        chk("R5 flush first cycle", 32'(pipe_flush), 32'h1);
        chk("R5 hold and mask", {30'h0, prefetch_hold, irq_mask}, 32'h3);
        tick();
        chk("R5 flush drops", 32'(pipe_flush), 32'h0);
        chk("R5 still holding", {30'h0, prefetch_hold, irq_mask}, 32'h3);

        // New events while halted are ignored
        evt_req = 5'b11111;
        evt_halt_class = 1'b1;
        ret_addr = 32'h0000_9000;
        tick();
        evt_req = '0;
        evt_halt_class = 1'b0;
        chk("R6 method unchanged", 32'(status[5:2]), 32'h1);
        chk("R8 pc unchanged by event", pc_rd, 32'h0000_0004);
        chk("R6 no new flush", 32'(pipe_flush), 32'h0);

        // Explicit PC write while halted
        pc_wr_en = 1'b1;
        pc_wr_data = 32'h0000_1234;
        tick();
        pc_wr_en = 1'b0;
        chk("R8 pc written", pc_rd, 32'h0000_1234);
        repeat (3) tick();
        chk("R8 pc holds", pc_rd, 32'h0000_1234);

        // Restart
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        chk("R9 side outputs drop", {29'h0, dbg_ack, prefetch_hold, irq_mask}, 32'h0);
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        chk("R9 restart while running", status, 32'h0000_4000);

        // PC write while running ignored
        pc_wr_en = 1'b1;
        pc_wr_data = 32'h0000_DEAD;
        tick();
        pc_wr_en = 1'b0;
        chk("R8 running pc write ignored", pc_rd, 32'h0000_1234);

        // Configuration port only touches bit 14
        cfg_wr_en = 1'b1;
        cfg_wr_data = 32'hFFFF_FFFF;
        tick();
        chk("R10 write all ones", status, 32'h0000_4000);
        cfg_wr_data = 32'h0000_0000;
        tick();
        cfg_wr_en = 1'b0;
        chk("R10 write zero", status, 32'h0000_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule